// File: doc/BRIEF.md
# Two-Client Turn-Based Mutex Arbiter

This block shares one critical resource between two clients, called A (index 0) and B (index 1). Each client has its own three-state controller. The states are idle, trying and critical, and exactly one of them is current at any time. A client raises its request to start trying. It holds the resource while its grant is high, and raises its release to give the resource back.

A single turn register settles the case where both clients are trying at once. The turn does not rotate on a free-running schedule. It moves only as the clients move: whenever one client is idle and the other is trying, the turn passes to the trying client. Everything is synchronous to one clock and changes on its rising edge. Reset is synchronous and active high.

Top module: `mutex_arb`

## Requirements
- R1: While `rst` is high at a rising edge, both clients become idle (grant and trying low) and `turnOwner` becomes 0 (client A) after that edge.
- R2: An idle client whose request bit is high at an edge shows trying after that edge. An idle client with its request low stays idle.
- R3: A trying client whose peer is idle shows grant after the next edge.
- R4: When both clients are trying, only the client named by `turnOwner` (0 = A, 1 = B) shows grant after the next edge. The other client stays trying.
- R5: A trying client whose peer holds grant stays trying.
- R6: A client holding grant with its release bit high at an edge becomes idle after that edge. With its release bit low, it keeps grant.
- R7: When one client is idle and the other is trying at an edge, `turnOwner` takes the trying client's index after that edge. In every other case `turnOwner` holds its value.
- R8: `grant[0]` and `grant[1]` are never high together.
- R9: Each client's state appears on a flag pair: grant=1 means critical, trying=1 means trying, and both low means idle. Both flags of one client are never high together.
- R10: A request bit has no effect unless its client is idle. A release bit has no effect unless its client holds grant.
- R11: Suppose every granted client releases within H cycles. Then a trying client waits at most H+3 cycles before it is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 2 | Request bit per client (bit 0 = A, bit 1 = B) |
| rel | input | 2 | Release bit per client |
| grant | output | 2 | Client is in its critical state |
| trying | output | 2 | Client is waiting for the resource |
| turnOwner | output | 1 | Client index that wins a tie |

## Verification
Directed sequences come first. A lone request on one client shows uncontested entry and the turn handover to that client. Both clients requesting on the same edge right after reset shows that the turn value alone decides the winner, and that the loser keeps waiting. A request made while the peer holds the resource shows that a granted peer blocks entry and that a stray release from a waiting client changes nothing. A long random phase follows, with frequent simultaneous requests and releases that come late but within a bound. Each cycle is compared against a behavioural model. Wait times are measured there, so a turn that fails to move shows up as starvation, not as a wrong winner.

// File: rtl/mutex_arb_pkg.sv
package mutex_arb_pkg;

  localparam int NUM_CLIENTS = 2;
  localparam int IDX_W = $clog2(NUM_CLIENTS);

  typedef enum logic [1:0] {
    CL_IDLE = 2'd0,
    CL_TRY  = 2'd1,
    CL_CRIT = 2'd2
  } clState_e;

  // strobes from control to the turn datapath
  typedef struct packed {
    logic passToA;
    logic passToB;
  } turnStrobe_t;

endpackage

// File: rtl/mutex_client_fsm.sv
module mutex_client_fsm
  import mutex_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reqIn,
  input  logic     relIn,
  input  logic     peerIdle,
  input  logic     peerTry,
  input  logic     myTurn,
  output clState_e stateQ
);

  clState_e stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      CL_IDLE: if (reqIn) stateD = CL_TRY;
      CL_TRY: begin
        if (peerIdle) stateD = CL_CRIT;
        else if (peerTry && myTurn) stateD = CL_CRIT;
      end
      CL_CRIT: if (relIn) stateD = CL_IDLE;
      default: stateD = CL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= CL_IDLE;
    else     stateQ <= stateD;
  end

endmodule

// File: rtl/mutex_arb_ctrl.sv
module mutex_arb_ctrl
  import mutex_arb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CLIENTS-1:0] req,
  input  logic [NUM_CLIENTS-1:0] rel,
  input  logic [IDX_W-1:0]       turnQ,
  output logic [NUM_CLIENTS-1:0] grantFlag,
  output logic [NUM_CLIENTS-1:0] tryFlag,
  output turnStrobe_t            strobe
);

  clState_e clState [NUM_CLIENTS];
  logic [NUM_CLIENTS-1:0] isIdle;

  for (genvar gi = 0; gi < NUM_CLIENTS; gi++) begin : g_client
    localparam int PEER = NUM_CLIENTS - 1 - gi;

    mutex_client_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .reqIn    (req[gi]),
      .relIn    (rel[gi]),
      .peerIdle (isIdle[PEER]),
      .peerTry  (tryFlag[PEER]),
      .myTurn   (turnQ == IDX_W'(gi)),
      .stateQ   (clState[gi])
    );

    assign isIdle[gi]    = (clState[gi] == CL_IDLE);
    assign tryFlag[gi]   = (clState[gi] == CL_TRY);
    assign grantFlag[gi] = (clState[gi] == CL_CRIT);
  end

  always_comb begin
    strobe.passToA = tryFlag[0] && isIdle[1];
    strobe.passToB = tryFlag[1] && isIdle[0];
  end

endmodule

// File: rtl/mutex_turn_dp.sv
module mutex_turn_dp
  import mutex_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  turnStrobe_t      strobe,
  output logic [IDX_W-1:0] turnQ
);

  always_ff @(posedge clk) begin
    if (rst)                 turnQ <= '0;
    else if (strobe.passToB) turnQ <= IDX_W'(1);
    else if (strobe.passToA) turnQ <= '0;
  end

endmodule

// File: rtl/mutex_arb.sv
module mutex_arb
  import mutex_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  input  logic [1:0] rel,
  output logic [1:0] grant,
  output logic [1:0] trying,
  output logic       turnOwner
);

  turnStrobe_t      strobe;
  logic [IDX_W-1:0] turnQ;

  mutex_arb_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .rel       (rel),
    .turnQ     (turnQ),
    .grantFlag (grant),
    .tryFlag   (trying),
    .strobe    (strobe)
  );

  mutex_turn_dp u_turn (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .turnQ  (turnQ)
  );

  assign turnOwner = turnQ;

endmodule

// File: rtl/mutex_arb_checker.sv
module mutex_arb_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] req,
  input logic [1:0] rel,
  input logic [1:0] grant,
  input logic [1:0] trying,
  input logic       turnOwner
);

  p_mutex_r8: assert property (@(posedge clk) disable iff (rst)
    !(grant[0] && grant[1]));

  p_flags_r9: assert property (@(posedge clk) disable iff (rst)
    !(grant[0] && trying[0]) && !(grant[1] && trying[1]));

  p_req_a_r2: assert property (@(posedge clk) disable iff (rst)
    (!grant[0] && !trying[0] && req[0]) |=> trying[0]);

  p_uncont_a_r3: assert property (@(posedge clk) disable iff (rst)
    (trying[0] && !grant[1] && !trying[1]) |=> grant[0]);

  p_contest_a_r4: assert property (@(posedge clk) disable iff (rst)
    (trying[0] && trying[1] && !turnOwner) |=> (grant[0] && trying[1]));

  p_contest_b_r4: assert property (@(posedge clk) disable iff (rst)
    (trying[0] && trying[1] && turnOwner) |=> (grant[1] && trying[0]));

  p_block_b_r5: assert property (@(posedge clk) disable iff (rst)
    (trying[1] && grant[0]) |=> trying[1]);

  p_release_b_r6: assert property (@(posedge clk) disable iff (rst)
    (grant[1] && rel[1]) |=> (!grant[1] && !trying[1]));

  p_turn_b_r7: assert property (@(posedge clk) disable iff (rst)
    (trying[1] && !grant[0] && !trying[0]) |=> turnOwner);

  p_turn_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (grant[0] || grant[1]) |=> $stable(turnOwner));

endmodule

bind mutex_arb mutex_arb_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .rel       (rel),
  .grant     (grant),
  .trying    (trying),
  .turnOwner (turnOwner)
);

// File: tb/mutex_arb_tb_top.sv
module mutex_arb_tb_top;

  localparam int MAX_HOLD   = 6;
  localparam int WAIT_LIMIT = MAX_HOLD + 3;
  localparam int RAND_CYCLES = 4000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] req = '0;
  logic [1:0] rel = '0;
  logic [1:0] grant;
  logic [1:0] trying;
  logic       turnOwner;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model: 0 idle, 1 trying, 2 critical
  int mSt [2];
  int mTurn;
  int waitCnt [2];
  int holdCnt [2];

  always #2 clk = ~clk;

  mutex_arb dut_i (
    .clk(clk), .rst(rst), .req(req), .rel(rel),
    .grant(grant), .trying(trying), .turnOwner(turnOwner)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive inputs at negedge, advance one clock, compare with model
  task automatic step(input logic [1:0] rq, input logic [1:0] rl, input logic rs);
    int nxt [2];
    int nTurn;
    string tag [2];
    @(negedge clk);
    req = rq; rel = rl; rst = rs;
    nTurn = mTurn;
    for (int i = 0; i < 2; i++) begin
      int peer;
      peer = 1 - i;
      if (rs) begin
        nxt[i] = 0; tag[i] = "R1";
      end else begin
        case (mSt[i])
          0: begin nxt[i] = rq[i] ? 1 : 0; tag[i] = "R2"; end
          1: begin
            if (mSt[peer] == 0)      begin nxt[i] = 2; tag[i] = "R3"; end
            else if (mSt[peer] == 1) begin nxt[i] = (mTurn == i) ? 2 : 1; tag[i] = "R4"; end
            else                     begin nxt[i] = 1; tag[i] = "R5"; end
          end
          default: begin nxt[i] = rl[i] ? 0 : 2; tag[i] = "R6"; end
        endcase
        if ((mSt[i] != 0 && rq[i]) || (mSt[i] != 2 && rl[i])) tag[i] = "R10";
      end
    end
    if (rs) nTurn = 0;
    else if (mSt[0] == 1 && mSt[1] == 0) nTurn = 0;
    else if (mSt[1] == 1 && mSt[0] == 0) nTurn = 1;
    @(posedge clk);
    #1;
    for (int i = 0; i < 2; i++) begin
      check(grant[i] == (nxt[i] == 2), tag[i], int'(grant[i]), int'(nxt[i] == 2));
      check(trying[i] == (nxt[i] == 1), tag[i], int'(trying[i]), int'(nxt[i] == 1));
      check(!(grant[i] && trying[i]), "R9", int'({grant[i], trying[i]}), 0);
      if (nxt[i] == 1) waitCnt[i]++;
      else begin
        if (mSt[i] == 1 && nxt[i] == 2)
          check(waitCnt[i] <= WAIT_LIMIT, "R11", waitCnt[i], WAIT_LIMIT);
        waitCnt[i] = 0;
      end
      if (nxt[i] == 1 && waitCnt[i] > WAIT_LIMIT)
        check(1'b0, "R11", waitCnt[i], WAIT_LIMIT);
      holdCnt[i] = (nxt[i] == 2) ? holdCnt[i] + 1 : 0;
      mSt[i] = nxt[i];
    end
    check(int'(turnOwner) == nTurn, rs ? "R1" : "R7", int'(turnOwner), nTurn);
    check(!(grant[0] && grant[1]), "R8", int'(grant), 0);
    mTurn = nTurn;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      mSt[i] = 0; waitCnt[i] = 0; holdCnt[i] = 0;
    end
    mTurn = 0;
    // R1: reset state
    step(2'b11, 2'b11, 1'b1);
    step(2'b00, 2'b00, 1'b1);
    // R4: simultaneous requests, turn is A after reset
    step(2'b11, 2'b00, 1'b0);
    step(2'b00, 2'b00, 1'b0);   // A granted, B stays trying (R4)
    step(2'b00, 2'b10, 1'b0);   // R10: B release while trying ignored, R5 blocked
    step(2'b00, 2'b01, 1'b0);   // A releases (R6)
    step(2'b00, 2'b00, 1'b0);   // B uncontested (R3), turn to B (R7)
    step(2'b01, 2'b00, 1'b0);   // A tries while B critical
    step(2'b00, 2'b00, 1'b0);   // R5
    step(2'b11, 2'b10, 1'b0);   // B releases, B req ignored (R10)
    step(2'b10, 2'b00, 1'b0);   // A enters, B requests
    step(2'b00, 2'b01, 1'b0);
    step(2'b00, 2'b00, 1'b0);
    step(2'b00, 2'b10, 1'b0);
    // random phase
    for (int c = 0; c < RAND_CYCLES; c++) begin
      logic [1:0] rq, rl;
      for (int i = 0; i < 2; i++) begin
        rq[i] = ($urandom % 3) != 0;
        rl[i] = (holdCnt[i] >= MAX_HOLD) ? 1'b1 : (($urandom % 4) == 0);
      end
      if ((c % 97) == 50) step(rq, rl, 1'b1);
      else                step(rq, rl, 1'b0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule